// File: doc/BRIEF.md
# Packed Pixel Frame Buffer Writer

This block takes a stream of 12-bit pixels and turns it into 16-bit word writes for a linear external memory. Every group of four pixels of a line becomes exactly three memory words with no unused bits. The first pixel of a frame carries a frame marker, the first pixel of each line carries a line marker, and the last pixel of each line carries an end-of-line marker. A line whose pixel count is not a multiple of four ends with one zero-padded word that holds the leftover bits. The next line then starts a fresh packing group.

Frames sit back to back in memory at any alignment. Nine base-address registers and one line-stride register are loaded through a small configuration write port. A frame-select input, sampled with the frame marker, picks the base address for that frame. Every further line starts one stride above the start of the previous line. Words within a line take consecutive addresses. Finished words leave through a single-entry valid/ready write port. When the port is held off, the pixel input stalls and nothing is lost. A counter reports how many words the current frame has written so far.

Top module: `pix_pack_writer`

## Requirements
- R1: In the cycle after a synchronous active-low reset, `wr_valid` is 0, `in_ready` is 1 and `frame_words` is 0.
- R2: Pixels p0..p3 of one group map to words w0..w2 least-significant bit first: w0 = {p1[3:0], p0}, w1 = {p2[7:0], p1[11:4]}, w2 = {p3, p2[11:8]}.
- R3: When a line ends with a group of 1, 2 or 3 pixels, the leftover bits are written as one extra word with the bits above them cleared. The input is held off until that word has been loaded into the output.
- R4: The first word of a frame is written to the base register chosen by `frame_sel` at the frame-marked pixel. Select values 9 to 15 use base register 0.
- R5: At each line marker that is not also a frame marker, the line start address is the previous line start plus the stride. Words within a line use consecutive addresses.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R7: `in_ready` is 0 whenever the output holds a word that is not being taken in that cycle.
- R8: A configuration write with `cfg_sel` 0 to 8 loads that base register, and a write with value 9 loads the stride. Values 10 to 15 change nothing.
- R9: `frame_words` counts output handshakes after the last accepted frame-marked pixel. It reads 0 right after that pixel is accepted.
- R10: A line of 4k pixels produces exactly 3k words, with no padding word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0..8 base, 9 stride |
| cfg_data | input | 20 | Configuration write value (word address) |
| frame_sel | input | 4 | Frame buffer select, used with the frame marker |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when valid |
| in_pixel | input | 12 | Pixel value |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| wr_valid | output | 1 | Word write pending |
| wr_ready | input | 1 | Memory side takes the word |
| wr_addr | output | 20 | Word address |
| wr_data | output | 16 | Packed word |
| frame_words | output | 20 | Words written in the current frame |

## Verification
The assertions assume well-formed lines: each frame opens with a frame-marked pixel, each line closes with an end-of-line pixel, and the stride and base registers are not rewritten during a frame. The stimulus follows these rules. Lines are built whole by one task that always sets the markers on the first and last pixels. Configuration writes are issued only while no frame is in flight. The ready line toggles freely, because backpressure is part of the legal input space.

// File: rtl/ppw_pkg.sv
// Shared constants and types for the packed pixel writer.
package ppw_pkg;
    localparam int PIX_W  = 12;
    localparam int WORD_W = 16;
    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic [1:0] {PH0, PH1, PH2, PH3} phase_t;
endpackage

// File: rtl/ppw_cfg_regs.sv
// Base address table plus line stride.
// Assumes: cfg_sel values 0..NUM_FRAMES-1 hit a base, NUM_FRAMES the stride.
module ppw_cfg_regs #(
    parameter int AW         = 20,
    parameter int NUM_FRAMES = 9,
    parameter int SEL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_data,
    input  logic [SEL_W-1:0] frame_sel,
    output logic [AW-1:0]    sel_base,
    output logic [AW-1:0]    stride
);
    logic [AW-1:0] base_vec [NUM_FRAMES];

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_base
        logic [AW-1:0] q;
        // one base register per frame buffer
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(g))
                q <= cfg_data;
        end
        assign base_vec[g] = q;
    end

    // stride register, loaded at the select value just past the bases
    always_ff @(posedge clk) begin
        if (!rst_n)
            stride <= '0;
        else if (cfg_we && cfg_sel == SEL_W'(NUM_FRAMES))
            stride <= cfg_data;
    end

    // frame select lookup, out-of-range falls back to buffer 0
    always_comb begin
        sel_base = base_vec[0];
        for (int i = 1; i < NUM_FRAMES; i++)
            if (frame_sel == SEL_W'(i))
                sel_base = base_vec[i];
    end

    p_cfg_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > SEL_W'(NUM_FRAMES)) |=> ($stable(stride) && $stable(base_vec[0])));
endmodule

// File: rtl/ppw_packer.sv
// Four-into-three pixel packer with end-of-line flush.
// Assumes: each line ends with an eol pixel; line_start forces phase 0.
module ppw_packer
    import ppw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  accept,
    input  logic  line_start,
    input  logic  eol,
    input  pix_t  pixel,
    input  logic  can_load,
    output logic  emit,
    output word_t emit_data,
    output logic  pend,
    output word_t flush_data
);
    phase_t phase_q, ph, nphase;
    pix_t   resid_q, nresid;
    logic   pend_set;

    // next phase, residue and word for the accepted pixel
    always_comb begin
        ph        = line_start ? PH0 : phase_q;
        emit      = 1'b1;
        emit_data = '0;
        nresid    = '0;
        nphase    = PH0;
        pend_set  = 1'b0;
        unique case (ph)
            PH0: begin
                emit      = eol;
                emit_data = {4'b0, pixel};
                nresid    = pixel;
                nphase    = eol ? PH0 : PH1;
            end
            PH1: begin
                emit_data = {pixel[3:0], resid_q};
                nresid    = {4'b0, pixel[11:4]};
                nphase    = eol ? PH0 : PH2;
                pend_set  = eol;
            end
            PH2: begin
                emit_data = {pixel[7:0], resid_q[7:0]};
                nresid    = {8'b0, pixel[11:8]};
                nphase    = eol ? PH0 : PH3;
                pend_set  = eol;
            end
            PH3: begin
                emit_data = {pixel, resid_q[3:0]};
                nphase    = PH0;
            end
        endcase
    end

    assign flush_data = {4'b0, resid_q};

    // packing state update and flush bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH0;
            resid_q <= '0;
            pend    <= 1'b0;
        end else if (accept) begin
            phase_q <= nphase;
            resid_q <= nresid;
            pend    <= pend_set;
        end else if (pend && can_load) begin
            pend    <= 1'b0;
        end
    end

    p_pend_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && can_load) |=> !pend);
    p_eol_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eol) |=> (phase_q == PH0));
endmodule

// File: rtl/ppw_addr_gen.sv
// Line base and word index tracking for frame/line addressing.
// Assumes: stride and bases stay constant while a frame is in flight.
module ppw_addr_gen #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          sof,
    input  logic          line_start,
    input  logic [AW-1:0] sel_base,
    input  logic [AW-1:0] stride,
    input  logic          load,
    output logic [AW-1:0] ld_addr
);
    logic [AW-1:0] line_base, word_idx, cur_base, cur_idx;
    logic          restart;

    // choose the line base and index that apply to this cycle
    always_comb begin
        restart  = accept && line_start;
        cur_base = line_base;
        if (accept && sof)
            cur_base = sel_base;
        else if (restart)
            cur_base = line_base + stride;
        cur_idx  = restart ? '0 : word_idx;
        ld_addr  = cur_base + cur_idx;
    end

    // advance base at line starts and index on every loaded word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            word_idx  <= '0;
        end else begin
            line_base <= cur_base;
            word_idx  <= cur_idx + AW'(load);
        end
    end

    p_addr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && load && !restart) |-> (ld_addr == $past(ld_addr) + AW'(1)));
endmodule

// File: rtl/ppw_out_stage.sv
// Single-entry word output register plus per-frame word counter.
// Assumes: load is only raised when can_load is high.
module ppw_out_stage
    import ppw_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  word_t         ld_data,
    input  logic          sof_acc,
    input  logic          wr_ready,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output word_t         wr_data,
    output logic          can_load,
    output logic [AW-1:0] frame_words
);
    assign can_load = !wr_valid || wr_ready;

    // hold a word until the memory side takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (load) begin
            wr_valid <= 1'b1;
            wr_addr  <= ld_addr;
            wr_data  <= ld_data;
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // count handshakes since the last frame start
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_words <= '0;
        else if (sof_acc)
            frame_words <= '0;
        else if (wr_valid && wr_ready)
            frame_words <= frame_words + AW'(1);
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && frame_words == '0));
    p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_acc |=> (frame_words == '0));
endmodule

// File: rtl/pix_pack_writer.sv
// Top: packs 12-bit pixels into 16-bit words and addresses them by
// frame base and line stride. Assumes well-formed lines (sol..eol).
module pix_pack_writer
    import ppw_pkg::*;
#(
    parameter int AW         = 20,
    parameter int NUM_FRAMES = 9,
    parameter int SEL_W      = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [AW-1:0]    cfg_data,
    input  logic [SEL_W-1:0] frame_sel,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [11:0]      in_pixel,
    input  logic             in_sof,
    input  logic             in_sol,
    input  logic             in_eol,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [15:0]      wr_data,
    output logic [AW-1:0]    frame_words
);
    logic [AW-1:0] sel_base, stride, ld_addr;
    logic          accept, line_start, emit, pend, can_load, load, flush_fire;
    word_t         emit_data, flush_data, ld_data;

    // input handshake and load selection
    always_comb begin
        in_ready   = can_load && !pend;
        accept     = in_valid && in_ready;
        line_start = in_sof || in_sol;
        flush_fire = pend && can_load;
        load       = (accept && emit) || flush_fire;
        ld_data    = pend ? flush_data : emit_data;
    end

    ppw_cfg_regs #(.AW(AW), .NUM_FRAMES(NUM_FRAMES), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .frame_sel(frame_sel),
        .sel_base(sel_base), .stride(stride)
    );

    ppw_packer u_pack (
        .clk(clk), .rst_n(rst_n), .accept(accept), .line_start(line_start),
        .eol(in_eol), .pixel(in_pixel), .can_load(can_load), .emit(emit),
        .emit_data(emit_data), .pend(pend), .flush_data(flush_data)
    );

    ppw_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .sof(in_sof),
        .line_start(line_start), .sel_base(sel_base), .stride(stride),
        .load(load), .ld_addr(ld_addr)
    );

    ppw_out_stage #(.AW(AW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
        .ld_data(ld_data), .sof_acc(accept && in_sof), .wr_ready(wr_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .can_load(can_load), .frame_words(frame_words)
    );

    p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);
    p_flush_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_fire) |-> (wr_data[15:12] == 4'b0));
endmodule

// File: tb/pix_pack_writer_bench.sv
`timescale 1ns/1ps
module pix_pack_writer_bench;
    localparam int AW = 20;
    localparam int NF = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cfg_we = 1'b0, in_valid = 1'b0, in_sof = 1'b0;
    logic in_sol = 1'b0, in_eol = 1'b0, wr_ready = 1'b1;
    logic [3:0] cfg_sel = '0, frame_sel = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [11:0] in_pixel = '0;
    logic in_ready, wr_valid;
    logic [AW-1:0] wr_addr, frame_words;
    logic [15:0] wr_data;

    pix_pack_writer u_pix_pack_writer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .frame_sel(frame_sel), .in_valid(in_valid),
        .in_ready(in_ready), .in_pixel(in_pixel), .in_sof(in_sof),
        .in_sol(in_sol), .in_eol(in_eol), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_words(frame_words)
    );

    int checks = 0, errors = 0;
    string cur_req = "R2";
    int base_m[NF];
    int stride_m = 0;
    int q_addr[$], q_data[$], hist[$];
    longint acc = 0;
    int nbits = 0, lbase = 0, widx = 0, cnt_m = 0;
    bit started = 0, throttle = 0, prev_stall = 0;
    logic [AW-1:0] prev_addr;
    logic [15:0] prev_data;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model: bit accumulator per line, addresses from base/stride
    task automatic model_pixel(int p, bit sof, bit sol, bit eol, int sel);
        if (sof) begin
            lbase = base_m[(sel < NF) ? sel : 0]; widx = 0; acc = 0; nbits = 0;
        end else if (sol) begin
            lbase = (lbase + stride_m) & 32'hFFFFF; widx = 0; acc = 0; nbits = 0;
        end
        acc = acc | (longint'(p) << nbits);
        nbits += 12;
        if (nbits >= 16) begin
            q_addr.push_back((lbase + widx) & 32'hFFFFF);
            q_data.push_back(int'(acc & 64'hFFFF));
            acc = acc >> 16; nbits -= 16; widx++;
        end
        if (eol && nbits > 0) begin
            q_addr.push_back((lbase + widx) & 32'hFFFFF);
            q_data.push_back(int'(acc & 64'hFFFF));
            acc = 0; nbits = 0; widx++;
        end
    endtask

    // per-cycle comparison, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(int'(frame_words) == cnt_m, "R9", "frame_words", int'(frame_words), cnt_m);
            if (prev_stall)
                chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R6",
                    "held word", int'(wr_data), int'(prev_data));
            if (wr_valid && !wr_ready)
                chk(!in_ready, "R7", "in_ready under stall", int'(in_ready), 0);
            if (wr_valid && wr_ready) begin
                hist.push_back(int'(wr_data));
                if (q_data.size() == 0) begin
                    chk(0, cur_req, "unexpected word", int'(wr_data), -1);
                end else begin
                    int ea, ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    chk(int'(wr_addr) == ea, cur_req, "address", int'(wr_addr), ea);
                    chk(int'(wr_data) == ed, cur_req, "data", int'(wr_data), ed);
                end
            end
            if (in_valid && in_ready)
                model_pixel(int'(in_pixel), in_sof, in_sol, in_eol, int'(frame_sel));
            if (in_valid && in_ready && in_sof) cnt_m = 0;
            else if (wr_valid && wr_ready) cnt_m++;
            prev_stall = wr_valid && !wr_ready;
            prev_addr = wr_addr;
            prev_data = wr_data;
        end
    end

    // memory-side ready pattern
    always @(posedge clk) begin
        #1;
        wr_ready = throttle ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic cfg_write(int sel, int val);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_data = AW'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel < NF) base_m[sel] = val & 32'hFFFFF;
        else if (sel == NF) stride_m = val & 32'hFFFFF;
    endtask

    task automatic send_pix(int p, bit sof, bit sol, bit eol);
        in_valid = 1'b1; in_pixel = 12'(p); in_sof = sof; in_sol = sol; in_eol = eol;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    endtask

    task automatic send_line(int n, bit first, int sel, int seed);
        frame_sel = 4'(sel);
        for (int k = 0; k < n; k++)
            send_pix((seed + k * 341) & 12'hFFF, first && k == 0, k == 0, k == n - 1);
    endtask

    task automatic drain();
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (q_data.size() == 0 && !wr_valid) break;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NF; i++) base_m[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid, "R1", "wr_valid after reset", int'(wr_valid), 0);
        chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(frame_words == '0, "R1", "frame_words after reset", int'(frame_words), 0);
        @(posedge clk); #1;
        started = 1;

        // R8: load bases at irregular offsets and a non power-of-two stride
        for (int i = 0; i < NF; i++) cfg_write(i, 1000 + i * 12345);
        cfg_write(NF, 777);

        // R2: one known group of four pixels
        cur_req = "R2";
        hist.delete();
        frame_sel = 4'd1;
        send_pix(12'hABC, 1, 1, 0);
        send_pix(12'h123, 0, 0, 0);
        send_pix(12'h456, 0, 0, 0);
        send_pix(12'h789, 0, 0, 1);
        drain();
        chk(hist.size() == 3, "R2", "group word count", hist.size(), 3);
        if (hist.size() == 3) begin
            chk(hist[0] == 16'h3ABC, "R2", "word0", hist[0], 16'h3ABC);
            chk(hist[1] == 16'h5612, "R2", "word1", hist[1], 16'h5612);
            chk(hist[2] == 16'h7894, "R2", "word2", hist[2], 16'h7894);
        end

        // R10 / R5: three lines of eight pixels each
        cur_req = "R5";
        for (int l = 0; l < 3; l++) send_line(8, l == 0, 2, 100 + l);
        drain();
        chk(frame_words == AW'(18), "R10", "words for 3x8 pixels", int'(frame_words), 18);
        chk(frame_words == AW'(18), "R9", "frame word count", int'(frame_words), 18);

        // R3: partial lines of 5, 6, 7 pixels
        cur_req = "R3";
        send_line(5, 1, 5, 7);
        send_line(6, 0, 5, 9);
        send_line(7, 0, 5, 11);
        drain();
        chk(frame_words == AW'(15), "R3", "words for 5/6/7 pixels", int'(frame_words), 15);

        // R4: out-of-range frame select falls back to buffer 0
        cur_req = "R4";
        send_line(3, 1, 12, 55);
        send_line(4, 0, 12, 66);
        drain();

        // R8: writes above the stride index are ignored
        cur_req = "R8";
        cfg_write(11, 20'h77777);
        cfg_write(15, 20'h12345);
        send_line(6, 1, 0, 200);
        send_line(2, 0, 0, 300);
        drain();

        // R6 / R7: random line lengths with throttled ready
        cur_req = "R6";
        throttle = 1;
        for (int f = 0; f < 3; f++) begin
            int sel;
            sel = $urandom_range(0, 8);
            for (int l = 0; l < 5; l++)
                send_line($urandom_range(1, 9), l == 0, sel, $urandom_range(0, 4095));
        end
        drain();
        throttle = 0;
        chk(q_data.size() == 0, "R6", "words left unsent", q_data.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule